// File: doc/BRIEF.md
# Spread-Spectrum Frequency Word Generator

This block forms the frequency control word for a programmable master oscillator. The word counts in steps of 10 kHz. A 5-bit span selector and a 10-bit fine code set the programmed (undithered) word. The span selector places the bottom of a 1024-step window, and each of its steps is worth 512 fine steps. A free-running triangle generator can pull the word below the programmed value to spread the emitted spectrum. The pull is never upward. Its peak depth is about 2 % or 4 % of the programmed word, and one full sweep takes 4096 master clock cycles.

The block drives three outputs. The first is the dithered word, which feeds a numerically controlled or voltage-controlled oscillator. The second is the programmed word. The third is a flag that is high while the programmed word lies inside the legal oscillator band. When the spread enable is switched on or off, the change waits for the next point where the triangle sits at zero. Because of this, the output word never jumps in the middle of a sweep.

Top module: `ssfw_gen`

## Requirements
- R1: One clock edge after `offset_code` and `dac_code` are sampled, `base_word` equals `offset_code * 512 + dac_code`.
- R2: `in_range` is 1 exactly when `base_word` lies between 6600 and 13300 inclusive, and is 0 otherwise.
- R3: While the spread is inactive, `freq_word` equals `base_word`.
- R4: `freq_word` is never greater than `base_word`.
- R5: The peak depth is `base_word * 41 / 2048` when the registered `depth_sel` is 1 (about 2 %), and `base_word * 41 / 1024` when it is 0 (about 4 %). Both divisions truncate. The applied pull is `depth * ramp / 2048`, truncated, and `freq_word = base_word - pull`.
- R6: A 12-bit phase counter starts at 0 after reset and advances by one every cycle. The ramp equals the low 11 phase bits while phase bit 11 is 0, and their bitwise inverse while it is 1. The ramp therefore climbs from 0 to 2047 and falls back over a 4096-cycle period.
- R7: The spread-active state takes the value of `dither_en` only at a clock edge where the current ramp value is 0, which happens at phases 4095 and 0. At every other edge a change of `dither_en` has no effect.
- R8: During reset, `freq_word`, `base_word` and `in_range` are all 0, and the spread is inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offset_code | input | 5 | Span selector, 512 fine steps per code |
| dac_code | input | 10 | Fine code, 10 kHz per step |
| depth_sel | input | 1 | 1 selects the ~2 % peak depth, 0 selects ~4 % |
| dither_en | input | 1 | Spread enable, applied at ramp zero points |
| freq_word | output | 16 | Dithered frequency word |
| base_word | output | 16 | Programmed frequency word |
| in_range | output | 1 | Programmed word lies within 6600..13300 |

## Verification
The hardest case to reach from the ports is a toggle of the spread enable in the exact cycle where the ramp is 0. Only that cycle may change the spread state, and a toggle one cycle earlier must not. The phase is never visible at the ports. The stimulus therefore counts cycles from reset release to know the phase. It places enable edges on the wrap cycle, one cycle before it, and in the middle of a sweep. Around each edge, the word is compared every cycle against a reference model. The band flag is exercised one step inside and one step outside each band limit.

// File: rtl/ssfw_pkg.sv
package ssfw_pkg;

   typedef enum logic {
      DEPTH_WIDE   = 1'b0,
      DEPTH_NARROW = 1'b1
   } depth_e;

   typedef enum int {
      MULT_NATIVE   = 0,
      MULT_SHIFTADD = 1
   } mult_style_e;

endpackage

// File: rtl/ssfw_base_reg.sv
module ssfw_base_reg #(
   parameter int OFS_W      = 5,
   parameter int DAC_W      = 10,
   parameter int WORD_W     = 16,
   parameter int SPAN_SHIFT = 9,
   parameter int WORD_MIN   = 6600,
   parameter int WORD_MAX   = 13300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [DAC_W-1:0]  dac_i,
   output logic [WORD_W-1:0] base_o,
   output logic              in_range_o
);

   localparam int SUM_W = WORD_W + 1;

   logic [SUM_W-1:0]  span_floor;
   logic [SUM_W-1:0]  word_sum;
   logic [WORD_W-1:0] word_next;
   logic              band_next;

   always_comb begin
      span_floor = SUM_W'(ofs_i) << SPAN_SHIFT;
      word_sum   = span_floor + SUM_W'(dac_i);
      word_next  = word_sum[WORD_W-1:0];
      band_next  = (word_sum >= SUM_W'(WORD_MIN)) && (word_sum <= SUM_W'(WORD_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o     <= '0;
         in_range_o <= 1'b0;
      end else begin
         base_o     <= word_next;
         in_range_o <= band_next;
      end
   end

endmodule

// File: rtl/ssfw_tri.sv
module ssfw_tri #(
   parameter int PHASE_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PHASE_W-1:0] phase_o,
   output logic [PHASE_W-2:0] ramp_o,
   output logic               zero_o
);

   localparam int RAMP_W = PHASE_W - 1;

   logic [PHASE_W-1:0] phase_q;
   logic               falling;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   always_comb begin
      falling = phase_q[PHASE_W-1];
      ramp_o  = phase_q[RAMP_W-1:0] ^ {RAMP_W{falling}};
      zero_o  = (ramp_o == '0);
      phase_o = phase_q;
   end

endmodule

// File: rtl/ssfw_dither.sv
module ssfw_dither
   import ssfw_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int RAMP_W        = 11,
   parameter int DEPTH_NUM     = 41,
   parameter int SHIFT_NARROW  = 11,
   parameter int SHIFT_WIDE    = 10,
   parameter int MULT_STYLE    = MULT_SHIFTADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] base_i,
   input  logic              sel_i,
   input  logic              en_i,
   input  logic [RAMP_W-1:0] ramp_i,
   input  logic              zero_i,
   output logic              active_o,
   output logic              sel_o,
   output logic [WORD_W-1:0] offset_o
);

   localparam int NUM_W  = $clog2(DEPTH_NUM + 1);
   localparam int PROD_W = WORD_W + NUM_W;
   localparam int OFF_W  = WORD_W + RAMP_W;

   depth_e            sel_q;
   logic              active_q;
   logic [PROD_W-1:0] prod;
   logic [WORD_W-1:0] depth;
   logic [OFF_W-1:0]  off_prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= DEPTH_WIDE;
         active_q <= 1'b0;
      end else begin
         sel_q <= depth_e'(sel_i);
         if (zero_i) active_q <= en_i;
      end
   end

   generate
      if (MULT_STYLE == MULT_SHIFTADD) begin : g_shiftadd
         always_comb begin
            prod = '0;
            for (int b = 0; b < NUM_W; b++) begin
               if (DEPTH_NUM[b]) prod = prod + (PROD_W'(base_i) << b);
            end
         end
      end else begin : g_native
         always_comb prod = PROD_W'(base_i) * PROD_W'(DEPTH_NUM);
      end
   endgenerate

   always_comb begin
      if (sel_q == DEPTH_NARROW) depth = WORD_W'(prod >> SHIFT_NARROW);
      else                       depth = WORD_W'(prod >> SHIFT_WIDE);
      off_prod = OFF_W'(depth) * OFF_W'(ramp_i);
      offset_o = active_q ? WORD_W'(off_prod >> RAMP_W) : '0;
      active_o = active_q;
      sel_o    = sel_q;
   end

endmodule

// File: rtl/ssfw_gen.sv
module ssfw_gen
   import ssfw_pkg::*;
#(
   parameter int OFS_W        = 5,
   parameter int DAC_W        = 10,
   parameter int WORD_W       = 16,
   parameter int SPAN_SHIFT   = 9,
   parameter int PHASE_W      = 12,
   parameter int WORD_MIN     = 6600,
   parameter int WORD_MAX     = 13300,
   parameter int DEPTH_NUM    = 41,
   parameter int SHIFT_NARROW = 11,
   parameter int SHIFT_WIDE   = 10,
   parameter int MULT_STYLE   = MULT_SHIFTADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  offset_code,
   input  logic [DAC_W-1:0]  dac_code,
   input  logic              depth_sel,
   input  logic              dither_en,
   output logic [WORD_W-1:0] freq_word,
   output logic [WORD_W-1:0] base_word,
   output logic              in_range
);

   localparam int RAMP_W = PHASE_W - 1;

   generate
      if (WORD_W < OFS_W + SPAN_SHIFT + 1) begin : g_bad_word_w
         $error("WORD_W too narrow for offset span plus fine code");
      end
      if (DAC_W > SPAN_SHIFT + 1) begin : g_bad_dac_w
         $error("fine code wider than one span step allows");
      end
      if (PHASE_W < 2) begin : g_bad_phase_w
         $error("PHASE_W must be at least 2");
      end
      if (SHIFT_NARROW <= SHIFT_WIDE) begin : g_bad_shift
         $error("narrow depth shift must exceed wide depth shift");
      end
      if (WORD_MIN > WORD_MAX) begin : g_bad_band
         $error("band limits reversed");
      end
      if (MULT_STYLE != MULT_NATIVE && MULT_STYLE != MULT_SHIFTADD) begin : g_bad_mult
         $error("unknown multiplier style");
      end
   endgenerate

   logic [WORD_W-1:0]  base_w;
   logic [WORD_W-1:0]  offset_w;
   logic [PHASE_W-1:0] phase_w;
   logic [RAMP_W-1:0]  ramp_w;
   logic               zero_w;
   logic               active_w;
   logic               sel_w;

   ssfw_base_reg #(
      .OFS_W      (OFS_W),
      .DAC_W      (DAC_W),
      .WORD_W     (WORD_W),
      .SPAN_SHIFT (SPAN_SHIFT),
      .WORD_MIN   (WORD_MIN),
      .WORD_MAX   (WORD_MAX)
   ) base_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ofs_i      (offset_code),
      .dac_i      (dac_code),
      .base_o     (base_w),
      .in_range_o (in_range)
   );

   ssfw_tri #(
      .PHASE_W (PHASE_W)
   ) tri_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_o (phase_w),
      .ramp_o  (ramp_w),
      .zero_o  (zero_w)
   );

   ssfw_dither #(
      .WORD_W       (WORD_W),
      .RAMP_W       (RAMP_W),
      .DEPTH_NUM    (DEPTH_NUM),
      .SHIFT_NARROW (SHIFT_NARROW),
      .SHIFT_WIDE   (SHIFT_WIDE),
      .MULT_STYLE   (MULT_STYLE)
   ) dith_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_i   (base_w),
      .sel_i    (depth_sel),
      .en_i     (dither_en),
      .ramp_i   (ramp_w),
      .zero_i   (zero_w),
      .active_o (active_w),
      .sel_o    (sel_w),
      .offset_o (offset_w)
   );

   always_comb begin
      base_word = base_w;
      freq_word = base_w - offset_w;
   end

endmodule

// File: rtl/ssfw_chk.sv
module ssfw_chk #(
   parameter int OFS_W        = 5,
   parameter int DAC_W        = 10,
   parameter int WORD_W       = 16,
   parameter int SPAN_SHIFT   = 9,
   parameter int PHASE_W      = 12,
   parameter int WORD_MIN     = 6600,
   parameter int WORD_MAX     = 13300,
   parameter int DEPTH_NUM    = 41,
   parameter int SHIFT_NARROW = 11,
   parameter int SHIFT_WIDE   = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic [OFS_W-1:0]   offset_code,
   input logic [DAC_W-1:0]   dac_code,
   input logic               dither_en,
   input logic [WORD_W-1:0]  freq_word,
   input logic [WORD_W-1:0]  base_word,
   input logic               in_range,
   input logic [PHASE_W-1:0] phase,
   input logic [PHASE_W-2:0] ramp,
   input logic               active,
   input logic               sel
);

   localparam int CHK_W = WORD_W + 8;

   logic [CHK_W-1:0] peak_bound;
   logic [CHK_W-1:0] pull;
   logic [CHK_W-1:0] base_expect;

   always_comb begin
      peak_bound  = (CHK_W'(base_word) * CHK_W'(DEPTH_NUM)) >> (sel ? SHIFT_NARROW : SHIFT_WIDE);
      pull        = CHK_W'(base_word) - CHK_W'(freq_word);
      base_expect = (CHK_W'(offset_code) << SPAN_SHIFT) + CHK_W'(dac_code);
   end

   AST_BASE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (CHK_W'(base_word) == $past(base_expect)));                    // R1

   AST_BAND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_range == ((base_word >= WORD_W'(WORD_MIN)) && (base_word <= WORD_W'(WORD_MAX)))); // R2

   AST_QUIET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (freq_word == base_word));                                  // R3

   AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      freq_word <= base_word);                                                // R4

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pull <= peak_bound);                                                    // R5

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (phase == PHASE_W'($past(phase) + 1'b1)));                     // R6

   AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp != '0) |=> $stable(active));                                      // R7

   AST_ENABLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp == '0) |=> (active == $past(dither_en)));                         // R7

endmodule

bind ssfw_gen ssfw_chk #(
   .OFS_W        (OFS_W),
   .DAC_W        (DAC_W),
   .WORD_W       (WORD_W),
   .SPAN_SHIFT   (SPAN_SHIFT),
   .PHASE_W      (PHASE_W),
   .WORD_MIN     (WORD_MIN),
   .WORD_MAX     (WORD_MAX),
   .DEPTH_NUM    (DEPTH_NUM),
   .SHIFT_NARROW (SHIFT_NARROW),
   .SHIFT_WIDE   (SHIFT_WIDE)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .offset_code (offset_code),
   .dac_code    (dac_code),
   .dither_en   (dither_en),
   .freq_word   (freq_word),
   .base_word   (base_word),
   .in_range    (in_range),
   .phase       (phase_w),
   .ramp        (ramp_w),
   .active      (active_w),
   .sel         (sel_w)
);

// File: tb/ssfw_gen_tb_top.sv
module ssfw_gen_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  offset_code = '0;
   logic [9:0]  dac_code = '0;
   logic        depth_sel = 1'b0;
   logic        dither_en = 1'b0;
   logic [15:0] freq_word;
   logic [15:0] base_word;
   logic        in_range;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   int m_phase  = 0;
   int m_active = 0;
   int m_base   = 0;
   int m_sel    = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ssfw_gen dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .offset_code (offset_code),
      .dac_code    (dac_code),
      .depth_sel   (depth_sel),
      .dither_en   (dither_en),
      .freq_word   (freq_word),
      .base_word   (base_word),
      .in_range    (in_range)
   );

   function automatic int tri_of(int p);
      return (p >= 2048) ? (4095 - p) : p;
   endfunction

   function automatic longint want_freq();
      longint depth;
      longint pull;
      depth = (longint'(m_base) * 41) / ((m_sel != 0) ? 2048 : 1024);
      pull  = (m_active != 0) ? (depth * tri_of(m_phase)) / 2048 : 0;
      return m_base - pull;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // Behavioural reference: state advanced on every edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_phase = 0; m_active = 0; m_base = 0; m_sel = 0;
      end else begin
         if (tri_of(m_phase) == 0) m_active = dither_en;
         m_phase = (m_phase + 1) % 4096;
         m_base  = offset_code * 512 + dac_code;
         m_sel   = depth_sel;
      end
      if (cycles > WATCHDOG && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         finish_run();
      end
   end

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 base_word", base_word, m_base);
         check("R2 in_range", in_range, (m_base >= 6600 && m_base <= 13300) ? 1 : 0);
         check("R4 no overshoot", (freq_word <= base_word) ? 1 : 0, 1);
         if (m_active == 0) check("R3 freq_word undithered", freq_word, m_base);
         else               check("R5 R6 freq_word dithered", freq_word, want_freq());
      end
   end

   task automatic hold(int ofs, int dac, int n);
      offset_code = 5'(ofs);
      dac_code    = 10'(dac);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_phase(int p);
      while (m_phase != p) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset values
      check("R8 freq_word in reset", freq_word, 0);
      check("R8 base_word in reset", base_word, 0);
      check("R8 in_range in reset", in_range, 0);
      rst_n = 1'b1;

      // Spread off: band edges and extremes (R1, R2, R3)
      hold(12, 456, 4);
      hold(12, 455, 4);
      hold(25, 500, 4);
      hold(25, 501, 4);
      hold(31, 1023, 4);
      hold(0, 0, 4);
      hold(18, 500, 4);
      hold(13, 1, 4);

      // Spread on, 4 % depth, full period plus margin (R5, R6)
      depth_sel = 1'b0;
      dither_en = 1'b1;
      hold(18, 500, 4300);

      // 2 % depth with a large word
      depth_sel = 1'b1;
      hold(25, 1023, 4300);

      // R7: disable in the middle of a sweep keeps the pull
      wait_phase(1000);
      dither_en = 1'b0;
      @(negedge clk);
      check("R7 pull held after mid-sweep disable", (freq_word < base_word) ? 1 : 0, 1);
      repeat (3200) @(negedge clk);
      check("R3 spread stopped after zero point", freq_word, base_word);

      // R7: enable placed on the wrap cycle
      wait_phase(4095);
      dither_en = 1'b1;
      depth_sel = 1'b0;
      hold(31, 1023, 4300);

      // R7: disable one cycle before the wrap cycle
      wait_phase(4094);
      dither_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7 disable taken at zero point", freq_word, base_word);

      // Change the word while the spread runs
      wait_phase(4095);
      dither_en = 1'b1;
      hold(20, 300, 1500);
      hold(22, 700, 1500);
      depth_sel = 1'b1;
      hold(16, 1000, 1500);

      finish_run();
   end

endmodule